// File: doc/BRIEF.md
# Clocked sequencer for an asynchronous static RAM

This block lets synchronous logic use an asynchronous static RAM. A host raises a request with a direction flag, an address and write data, and keeps it raised until a one-clock done pulse comes back. A read carries its data on that pulse. The block drives the RAM's address, active-low chip select, write strobe and output enable, plus the data going into the RAM. Every control output comes straight from a flop, so none of them glitches.

Each timing limit of the RAM is a parameter in picoseconds. The block turns each limit into a clock count: the limit divided by the clock period, rounded up, and never less than one cycle. Writes are strobed by the write line while chip select stays low. Output enable stays high for the whole of every write. At least one cycle with chip select high separates two accesses, so a read's output drivers are off before a write starts.

Top module: `sram_seq_ctrl`

## Requirements
- R1: After reset, chip select, write strobe and output enable are all high and the done pulse is low.
- R2: A read holds chip select and output enable low, with the write strobe high, for exactly the read window. The read window is the largest of the rounded access time, read cycle time and output-enable access time. The RAM data present at the end of the window appears on the read data output, together with done.
- R3: Output enable is never low while the write strobe is low. Output enable stays high through every write.
- R4: A write keeps chip select low and the address valid for the setup count before the write strobe falls. It then holds the strobe low for the pulse count. The pulse count covers the strobe width, and setup plus pulse covers the address-valid-to-strobe-rise time.
- R5: The write data is driven from the start of the write and does not change while the strobe is low. It is stable for at least the data setup time before the strobe rises. A later read of the same address returns it.
- R6: The address does not change while chip select is low.
- R7: Between two accesses, chip select stays high for at least the gap count. The gap count is the rounded output-disable time, and at least one cycle.
- R8: Each accepted request yields exactly one done pulse, one clock long. Requests are taken only when the block is idle.
- R9: Each chip-select-low span lasts at least the cycle time. After a write strobe rises, chip select stays low for at least the recovery count.
- R10: Each interval in clocks is the limit divided by the clock period, rounded up, and at least one. The write pulse lasts exactly the count derived this way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request, held by the host until done |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Write data |
| rsp_rdata | output | DW | Read data, valid with done |
| rsp_done | output | 1 | One-clock completion pulse |
| sram_addr | output | AW | RAM address |
| sram_cs_n | output | 1 | RAM chip select, active low |
| sram_we_n | output | 1 | RAM write strobe, active low |
| sram_oe_n | output | 1 | RAM output enable, active low |
| sram_din | output | DW | Data driven into the RAM |
| sram_dout | input | DW | Data returned by the RAM |

## Verification
The bench builds the block with a 5 ns clock and the default limits. It uses a 6-bit address and 1-bit data so that its RAM model covers every word. With these values the read window, setup, pulse, recovery and gap counts come to 3, 1, 3, 1 and 2 cycles. The 12 ns strobe width and the 7 ns output-disable time therefore fall between whole periods, which tests the round-up. Back-to-back requests push chip select to its shortest high time. The timing-checking model returns inverted data when a read samples too early, so a window that is too short shows up as wrong read data.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_WSU,
    ST_WPL,
    ST_WRC,
    ST_GAP
  } seq_st_e;

  // limit in ps over clock period in ps, rounded up, at least one cycle
  function automatic int ps2cyc(input int lim_ps, input int clk_ps);
    int c;
    c = (lim_ps + clk_ps - 1) / clk_ps;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_seq_timer.sv
module sram_seq_timer #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/sram_seq_datapath.sv
module sram_seq_datapath #(
  parameter int AW = 22,
  parameter int DW = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] wdata_in,
  input  logic          sample,
  input  logic [DW-1:0] dout_in,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] din_q,
  output logic [DW-1:0] rdata_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      din_q  <= '0;
    end else if (take) begin
      addr_q <= addr_in;
      din_q  <= wdata_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (sample) rdata_q <= dout_in;
  end
endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
  import sram_seq_pkg::*;
#(
  parameter int AW       = 22,
  parameter int DW       = 1,
  parameter int CLK_PS   = 5000,
  parameter int T_AA_PS  = 15000, // address / select access
  parameter int T_RC_PS  = 15000, // read cycle
  parameter int T_OEA_PS = 8000,  // output-enable access
  parameter int T_WC_PS  = 15000, // write cycle
  parameter int T_WP_PS  = 12000, // strobe low width
  parameter int T_AS_PS  = 0,     // address setup to strobe fall
  parameter int T_AW_PS  = 12000, // address valid to strobe rise
  parameter int T_DS_PS  = 7000,  // data setup to strobe rise
  parameter int T_WR_PS  = 1000,  // recovery after strobe rise
  parameter int T_OHZ_PS = 7000   // output disable
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic [DW-1:0] rsp_rdata,
  output logic          rsp_done,
  output logic [AW-1:0] sram_addr,
  output logic          sram_cs_n,
  output logic          sram_we_n,
  output logic          sram_oe_n,
  output logic [DW-1:0] sram_din,
  input  logic [DW-1:0] sram_dout
);
  localparam int RD_CYC  = imax(imax(ps2cyc(T_AA_PS, CLK_PS), ps2cyc(T_RC_PS, CLK_PS)),
                                ps2cyc(T_OEA_PS, CLK_PS));
  localparam int SU_CYC  = ps2cyc(T_AS_PS, CLK_PS);
  localparam int PW_CYC  = imax(imax(ps2cyc(T_WP_PS, CLK_PS), ps2cyc(T_DS_PS, CLK_PS)),
                                ps2cyc(T_AW_PS, CLK_PS) - SU_CYC);
  localparam int REC_CYC = imax(ps2cyc(T_WR_PS, CLK_PS),
                                ps2cyc(T_WC_PS, CLK_PS) - SU_CYC - PW_CYC);
  localparam int GAP_CYC = ps2cyc(T_OHZ_PS, CLK_PS);
  localparam int MAX_CYC = imax(imax(RD_CYC, SU_CYC), imax(imax(PW_CYC, REC_CYC), GAP_CYC));
  localparam int CW      = imax($clog2(MAX_CYC + 1), 1);

  seq_st_e       state;
  logic          tmr_load, tmr_zero;
  logic [CW-1:0] tmr_val;

  // named internal events
  logic ev_accept, ev_sample, ev_we_fall, ev_we_rise, ev_release, ev_gap_end;
  assign ev_accept  = (state == ST_IDLE) && req;
  assign ev_sample  = (state == ST_RD)   && tmr_zero;
  assign ev_we_fall = (state == ST_WSU)  && tmr_zero;
  assign ev_we_rise = (state == ST_WPL)  && tmr_zero;
  assign ev_release = (state == ST_WRC)  && tmr_zero;
  assign ev_gap_end = (state == ST_GAP)  && tmr_zero;

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (ev_accept) begin
      tmr_load = 1'b1;
      tmr_val  = req_we ? CW'(SU_CYC - 1) : CW'(RD_CYC - 1);
    end else if (ev_sample || ev_release) begin
      tmr_load = 1'b1;
      tmr_val  = CW'(GAP_CYC - 1);
    end else if (ev_we_fall) begin
      tmr_load = 1'b1;
      tmr_val  = CW'(PW_CYC - 1);
    end else if (ev_we_rise) begin
      tmr_load = 1'b1;
      tmr_val  = CW'(REC_CYC - 1);
    end
  end

  sram_seq_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  sram_seq_datapath #(.AW(AW), .DW(DW)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (ev_accept),
    .addr_in  (req_addr),
    .wdata_in (req_wdata),
    .sample   (ev_sample),
    .dout_in  (sram_dout),
    .addr_q   (sram_addr),
    .din_q    (sram_din),
    .rdata_q  (rsp_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      sram_cs_n <= 1'b1;
      sram_we_n <= 1'b1;
      sram_oe_n <= 1'b1;
      rsp_done  <= 1'b0;
    end else begin
      rsp_done <= 1'b0;
      if (ev_accept) begin
        sram_cs_n <= 1'b0;
        if (req_we) begin
          state <= ST_WSU;
        end else begin
          sram_oe_n <= 1'b0;
          state     <= ST_RD;
        end
      end
      if (ev_sample) begin
        sram_cs_n <= 1'b1;
        sram_oe_n <= 1'b1;
        rsp_done  <= 1'b1;
        state     <= ST_GAP;
      end
      if (ev_we_fall) begin
        sram_we_n <= 1'b0;
        state     <= ST_WPL;
      end
      if (ev_we_rise) begin
        sram_we_n <= 1'b1;
        rsp_done  <= 1'b1;
        state     <= ST_WRC;
      end
      if (ev_release) begin
        sram_cs_n <= 1'b1;
        state     <= ST_GAP;
      end
      if (ev_gap_end) state <= ST_IDLE;
    end
  end
endmodule

// File: rtl/sram_seq_chk.sv
module sram_seq_chk #(
  parameter int AW      = 22,
  parameter int DW      = 1,
  parameter int GAP_CYC = 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n,
  input logic          we_n,
  input logic          oe_n,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] din,
  input logic          done,
  input logic          ev_accept,
  input logic          ev_sample
);
  int hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 hi_cnt <= 0;
    else if (!cs_n)             hi_cnt <= 0;
    else if (hi_cnt < 1000000)  hi_cnt <= hi_cnt + 1;
  end

  // R3
  oe_off_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> we_n);

  // R4
  strobe_needs_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> !cs_n);

  // R6
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $past(!cs_n)) |-> $stable(addr));

  // R5
  din_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n && $past(!we_n)) |-> $stable(din));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  accept_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |-> cs_n);

  // R2
  sample_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sample |-> (!cs_n && !oe_n && we_n));

  // R7
  gap_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $past(cs_n)) |-> (hi_cnt >= GAP_CYC));
endmodule

bind sram_seq_ctrl sram_seq_chk #(.AW(AW), .DW(DW), .GAP_CYC(GAP_CYC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_n      (sram_cs_n),
  .we_n      (sram_we_n),
  .oe_n      (sram_oe_n),
  .addr      (sram_addr),
  .din       (sram_din),
  .done      (rsp_done),
  .ev_accept (ev_accept),
  .ev_sample (ev_sample)
);

// File: tb/test_sram_seq_ctrl.sv
module test_sram_seq_ctrl;
  localparam int AW = 6;
  localparam int DW = 1;
  localparam int TP = 5000;  // ps
  localparam int WORDS = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [DW-1:0] rsp_rdata, sram_din;
  logic [DW-1:0] sram_dout = '0;
  logic rsp_done, sram_cs_n, sram_we_n, sram_oe_n;
  logic [AW-1:0] sram_addr;

  always #2.5 clk = ~clk;

  sram_seq_ctrl #(.AW(AW), .DW(DW), .CLK_PS(TP)) i_sram_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .rsp_done(rsp_done),
    .sram_addr(sram_addr), .sram_cs_n(sram_cs_n), .sram_we_n(sram_we_n),
    .sram_oe_n(sram_oe_n), .sram_din(sram_din), .sram_dout(sram_dout)
  );

  int n_cmp = 0, n_bad = 0;

  task automatic check(input bit ok, input string rq, input string what,
                       input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  // bench-side cycle counts: smallest whole count of periods covering the limit
  function automatic int bcyc(input int ps);
    int n = 0;
    while (n * TP < ps) n++;
    return (n == 0) ? 1 : n;
  endfunction
  function automatic int bmax(input int a, input int b);
    if (a > b) return a;
    return b;
  endfunction

  // ---------------- RAM model with interval checks ----------------
  logic [DW-1:0] mem [WORDS];
  logic [DW-1:0] shadow [WORDS];
  int cs_lo, cs_hi, we_lo, oe_lo, din_st, rec;
  bit was_write, prev_cs_n, prev_we_n;
  logic [AW-1:0] prev_addr;
  logic [DW-1:0] prev_din;
  int exp_rd, exp_pw;

  initial begin
    for (int i = 0; i < WORDS; i++) begin
      mem[i] = '0;
      shadow[i] = '0;
    end
    exp_rd = bmax(bcyc(15000), bcyc(8000));
    exp_pw = bmax(bmax(bcyc(12000), bcyc(7000)), bcyc(12000) - bcyc(0));
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      cs_lo = 0; cs_hi = 100; we_lo = 0; oe_lo = 0; din_st = 0; rec = 0;
      was_write = 0; prev_cs_n = 1; prev_we_n = 1; prev_addr = '0; prev_din = '0;
    end else begin
      if (!sram_oe_n && !sram_we_n)
        check(0, "R3", "output enable low during strobe", 0, 1);
      if (!sram_we_n && sram_cs_n)
        check(0, "R4", "strobe low without select", 0, 1);
      // chip select edges
      if (!sram_cs_n && prev_cs_n) begin
        check(cs_hi * TP >= 7000 && cs_hi >= 1, "R7", "select high gap ps", cs_hi * TP, 7000);
        cs_lo = 0; oe_lo = 0; was_write = 0; rec = 0;
      end
      if (sram_cs_n && !prev_cs_n) begin
        check(cs_lo * TP >= 15000, "R9", "select low span ps", cs_lo * TP, 15000);
        if (was_write)
          check(rec * TP >= 1000, "R9", "recovery ps", rec * TP, 1000);
        else
          check(cs_lo == exp_rd, "R2", "read window cycles", cs_lo, exp_rd);
        cs_hi = 0;
      end
      if (!sram_cs_n && !prev_cs_n && sram_addr != prev_addr)
        check(0, "R6", "address moved under select", int'(sram_addr), int'(prev_addr));
      // strobe rise: checks use counts up to the previous period
      if (sram_we_n && !prev_we_n) begin
        check(we_lo * TP >= 12000, "R4", "strobe width ps", we_lo * TP, 12000);
        check(we_lo == exp_pw, "R10", "strobe cycles", we_lo, exp_pw);
        check(cs_lo * TP >= 12000, "R4", "address to strobe rise ps", cs_lo * TP, 12000);
        check(din_st * TP >= 7000, "R5", "data setup ps", din_st * TP, 7000);
        mem[prev_addr] = prev_din;
        was_write = 1;
        rec = 0;
      end
      if (!sram_we_n && prev_we_n) we_lo = 0;
      // counters for the period that ends at the next edge
      if (sram_din != prev_din) din_st = 0;
      din_st++;
      if (!sram_cs_n) cs_lo++; else cs_hi++;
      if (!sram_we_n) we_lo++;
      if (!sram_oe_n) oe_lo++; else oe_lo = 0;
      if (!sram_cs_n && sram_we_n && was_write) rec++;
      // read data: inverted when sampled before access time
      if (!sram_cs_n && !sram_oe_n && sram_we_n && cs_lo * TP >= 15000 && oe_lo * TP >= 8000)
        sram_dout = mem[sram_addr];
      else
        sram_dout = ~mem[sram_addr];
      prev_cs_n = sram_cs_n; prev_we_n = sram_we_n;
      prev_addr = sram_addr; prev_din = sram_din;
    end
  end

  // ---------------- scoreboard ----------------
  typedef struct { bit is_rd; logic [DW-1:0] d; logic [AW-1:0] a; } exp_t;
  exp_t sb[$];
  int issued = 0, popped = 0;
  bit prev_done = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (rsp_done && prev_done) check(0, "R8", "done longer than one clock", 2, 1);
      if (rsp_done) begin
        if (sb.size() == 0) check(0, "R8", "done without request", 1, 0);
        else begin
          exp_t e;
          e = sb.pop_front();
          popped++;
          if (e.is_rd)
            check(rsp_rdata === e.d, "R2", $sformatf("read data @%0d", e.a),
                  int'(rsp_rdata), int'(e.d));
        end
      end
      prev_done = rsp_done;
    end
  end

  task automatic issue(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d);
    exp_t e;
    @(negedge clk);
    req = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    e.is_rd = !we; e.a = a;
    if (we) begin
      shadow[a] = d;
      e.d = d;
    end else e.d = shadow[a];
    sb.push_back(e);
    issued++;
    do @(negedge clk); while (!rsp_done);
    req = 1'b0;
  endtask

  task automatic run();
    repeat (3) @(negedge clk);
    // R1 reset state
    check(sram_cs_n && sram_we_n && sram_oe_n, "R1", "controls idle in reset", 0, 1);
    check(!rsp_done, "R1", "done low in reset", int'(rsp_done), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(sram_cs_n && sram_we_n && sram_oe_n, "R1", "controls idle after reset", 0, 1);
    // boundary addresses, then readback (R5)
    issue(1, 6'd0, 1'b1);
    issue(1, 6'd63, 1'b1);
    issue(0, 6'd0, 'x);
    issue(0, 6'd63, 'x);
    issue(0, 6'd10, 'x);           // never written
    issue(1, 6'd0, 1'b0);          // overwrite
    issue(0, 6'd0, 'x);
    // read then write back to back, same address (R7)
    issue(0, 6'd63, 'x);
    issue(1, 6'd63, 1'b0);
    issue(0, 6'd63, 'x);
    // pattern fill and readback with varied spacing
    for (int a = 0; a < 16; a++) begin
      issue(1, AW'(a), DW'(a[0] ^ a[2]));
      if (a % 5 == 0) repeat (3) @(negedge clk);
    end
    for (int a = 15; a >= 0; a--) issue(0, AW'(a), 'x);
    repeat (6) @(negedge clk);
    check(issued == popped, "R8", "done count", popped, issued);
    check(sb.size() == 0, "R8", "pending results", sb.size(), 0);
  endtask

  initial begin
    fork
      run();
      begin
        repeat (100000) @(posedge clk);
        check(0, "R8", "watchdog expired", 1, 0);
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule